// File: doc/BRIEF.md
# Fractional Clock Output Prescaler

This block makes an internal clock visible on an output pin. A prescaler divides a reference clock by 1, 1.5 or 2.5. The prescaled clock and three auxiliary clock inputs feed a four-way selector, and a two-bit select picks which of them drives the pin. Each rising edge of the prescaled clock also produces a one-tick interrupt request pulse.

Ratios of 1.5 and 2.5 are not whole numbers of reference cycles. For that reason the block runs on a clock at twice the reference rate, so each of its cycles (a "tick") is one reference half-cycle. A period of 1.5 is then three ticks and a period of 2.5 is five ticks. The output is high for exactly one tick of each period. All outputs come from registers, so they do not glitch. The auxiliary inputs are sampled on the same fast clock.

Top module: `frac_clkout_gen`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_2x`, `clk_out` and `irq_pulse` are low after that edge, and the prescaler restarts in divide-by-1.
- R2: With `ratio_sel` = 2'b00 (divide-by-1), the prescaled clock has a period of 2 ticks and is high for 1 of them (50% duty).
- R3: With `ratio_sel` = 2'b01 (divide-by-1.5), the prescaled clock has a period of 3 ticks and is high for 1 of them (33% duty).
- R4: With `ratio_sel` = 2'b10 (divide-by-2.5), the prescaled clock has a period of 5 ticks and is high for 1 of them (20% duty).
- R5: `ratio_sel` = 2'b11 is reserved and gives the same waveform as divide-by-1.
- R6: A new `ratio_sel` value is taken up only when the current prescaled period ends. The new period then counts from its first tick, so the old period is never cut short.
- R7: `irq_pulse` is high for exactly one tick per prescaled period. This is the tick in which the prescaled clock (as seen on `clk_out` with `out_sel` = 2'b00) goes from low to high.
- R8: `out_sel` 2'b00 routes the prescaled clock to `clk_out`. The values 2'b01, 2'b10 and 2'b11 route `aux_clk[0]`, `aux_clk[1]` and `aux_clk[2]` in that order. `clk_out` follows the chosen source with one tick of latency.
- R9: `irq_pulse` keeps its rate when `out_sel` selects an auxiliary clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Fast clock at twice the reference rate; one cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Prescaler ratio: 00 = /1, 01 = /1.5, 10 = /2.5, 11 = /1 |
| out_sel | input | SEL_W (2) | Output source select: 00 = prescaled, 01..11 = aux_clk[0..2] |
| aux_clk | input | NUM_AUX (3) | Auxiliary clock candidates, sampled on clk_2x |
| clk_out | output | 1 | Registered selected clock |
| irq_pulse | output | 1 | One-tick pulse on each prescaled rising edge |

## Verification
The bench first locks onto an interrupt pulse. It then measures the full period and the single high tick for each ratio code, including the reserved code. A counter that wrapped one tick early or late, or a duty of more than one tick, shows up as a mistimed high sample. The ratio is then switched from 2.5 to 1 right after a rising edge. A design that applied the change at once would produce an early high within the remaining four ticks of the old period. The bench also walks every selector code with opposing auxiliary levels, which exposes a swapped or shifted routing. Finally it counts interrupt pulses while an auxiliary clock is on the pin, which catches an interrupt that was gated by the output selection.

// File: rtl/frac_clkout_pkg.sv
package frac_clkout_pkg;

    // Ticks per prescaled period, one tick per reference half-cycle.
    localparam int HALF_DIV1   = 2;
    localparam int HALF_DIV1P5 = 3;
    localparam int HALF_DIV2P5 = 5;
    localparam int HALF_MAX    = HALF_DIV2P5;
    localparam int CNT_W       = $clog2(HALF_MAX);

    typedef enum logic [1:0] {
        MODE_DIV1   = 2'd0,
        MODE_DIV1P5 = 2'd1,
        MODE_DIV2P5 = 2'd2
    } mode_t;

    typedef struct packed {
        mode_t              mode;
        logic [CNT_W-1:0]   cnt;
    } phase_t;

    // Reserved code 2'b11 falls back to divide-by-1.
    function automatic mode_t decode_ratio(input logic [1:0] code);
        case (code)
            2'b01:   return MODE_DIV1P5;
            2'b10:   return MODE_DIV2P5;
            default: return MODE_DIV1;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] last_tick(input mode_t m);
        case (m)
            MODE_DIV1P5: return CNT_W'(HALF_DIV1P5 - 1);
            MODE_DIV2P5: return CNT_W'(HALF_DIV2P5 - 1);
            default:     return CNT_W'(HALF_DIV1 - 1);
        endcase
    endfunction

endpackage

// File: rtl/fcp_halfcount.sv
module fcp_halfcount
    import frac_clkout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    output logic       pre_clk
);

    phase_t phase_q;
    logic   pre_q;
    logic   at_end;

    assign at_end = (phase_q.cnt == last_tick(phase_q.mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q.mode <= MODE_DIV1;
            phase_q.cnt  <= '0;
            pre_q        <= 1'b0;
        end else begin
            pre_q <= (phase_q.cnt == '0);
            if (at_end) begin
                phase_q.cnt  <= '0;
                phase_q.mode <= decode_ratio(ratio_sel);
            end else begin
                phase_q.cnt  <= phase_q.cnt + 1'b1;
            end
        end
    end

    assign pre_clk = pre_q;

    // R6: the count never passes the last tick of the active ratio
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        phase_q.cnt <= last_tick(phase_q.mode));

    // R6: the ratio holds for as long as a period is in progress
    p_ratio_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(phase_q.mode));

endmodule

// File: rtl/fcp_edge_pulse.sv
module fcp_edge_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic pulse_out
);

    logic prev_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= level_in;
            pulse_q <= level_in & ~prev_q;
        end
    end

    assign pulse_out = pulse_q;

    // R7: every pulse lasts exactly one tick
    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/fcp_clk_select.sv
module fcp_clk_select #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    output logic               out_clk
);

    logic out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= src[sel];
    end

    assign out_clk = out_q;

    // R8: each select code routes its own source with one tick of latency
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_route_chk
        p_route_r8: assert property (@(posedge clk) disable iff (rst)
            (sel == SEL_W'(g)) |=> (out_q == $past(src[g])));
    end

endmodule

// File: rtl/frac_clkout_gen.sv
module frac_clkout_gen #(
    parameter int NUM_AUX = 3,
    localparam int NUM_SRC = NUM_AUX + 1,
    localparam int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk_2x,
    input  logic               rst,
    input  logic [1:0]         ratio_sel,
    input  logic [SEL_W-1:0]   out_sel,
    input  logic [NUM_AUX-1:0] aux_clk,
    output logic               clk_out,
    output logic               irq_pulse
);

    logic               pre_clk;
    logic [NUM_SRC-1:0] cand;

    fcp_halfcount u_count (
        .clk       (clk_2x),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .pre_clk   (pre_clk)
    );

    fcp_edge_pulse u_irq (
        .clk       (clk_2x),
        .rst       (rst),
        .level_in  (pre_clk),
        .pulse_out (irq_pulse)
    );

    assign cand = {aux_clk, pre_clk};

    fcp_clk_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .clk     (clk_2x),
        .rst     (rst),
        .sel     (out_sel),
        .src     (cand),
        .out_clk (clk_out)
    );

    // R7: each prescaled rising edge is followed by an interrupt pulse
    p_irq_follows_rise_r7: assert property (@(posedge clk_2x) disable iff (rst)
        $rose(pre_clk) |=> irq_pulse);

    // R9: a pulse only ever follows a prescaled high tick, whatever out_sel is
    p_irq_source_r9: assert property (@(posedge clk_2x) disable iff (rst)
        irq_pulse |-> $past(pre_clk));

endmodule

// File: tb/frac_clkout_gen_tb_top.sv
module frac_clkout_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [1:0] code;
        logic [3:0] period;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{code: 2'b00, period: 4'd2},
        '{code: 2'b01, period: 4'd3},
        '{code: 2'b10, period: 4'd5},
        '{code: 2'b11, period: 4'd2},
        '{code: 2'b01, period: 4'd3}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ratio_sel;
    logic [1:0] out_sel;
    logic [2:0] aux_clk;
    logic       clk_out;
    logic       irq_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_clkout_gen dut_i (
        .clk_2x    (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .out_sel   (out_sel),
        .aux_clk   (aux_clk),
        .clk_out   (clk_out),
        .irq_pulse (irq_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    endtask

    function automatic string tag_of(input logic [1:0] code);
        case (code)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic sync_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_pulse) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        report();
    end

    initial begin
        bit seen;
        rst       = 1'b1;
        ratio_sel = 2'b10;
        out_sel   = 2'b00;
        aux_clk   = 3'b111;
        repeat (3) @(negedge clk);
        // R1: outputs are quiet during reset
        check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
        check(irq_pulse == 1'b0, "R1 irq_pulse", irq_pulse, 0);
        aux_clk   = 3'b000;
        ratio_sel = 2'b00;
        rst       = 1'b0;

        // Ratio table: lock on a pulse, then measure one full period
        for (int v = 0; v < NVEC; v++) begin
            ratio_sel = VECS[v].code;
            repeat (12) @(negedge clk);
            sync_irq(seen);
            check(seen, {tag_of(VECS[v].code), " lock"}, seen, 1);
            check(clk_out == 1'b1, {tag_of(VECS[v].code), " R7 high with pulse"}, clk_out, 1);
            for (int k = 1; k <= int'(VECS[v].period); k++) begin
                @(negedge clk);
                if (k < int'(VECS[v].period)) begin
                    check(clk_out == 1'b0, {tag_of(VECS[v].code), " low tick"}, clk_out, 0);
                    check(irq_pulse == 1'b0, {tag_of(VECS[v].code), " R7 no pulse"}, irq_pulse, 0);
                end else begin
                    check(clk_out == 1'b1, {tag_of(VECS[v].code), " period end"}, clk_out, 1);
                    check(irq_pulse == 1'b1, {tag_of(VECS[v].code), " R7 pulse"}, irq_pulse, 1);
                end
            end
        end

        // R6: switch from 2.5 to 1 right after a rising edge
        ratio_sel = 2'b10;
        repeat (12) @(negedge clk);
        sync_irq(seen);
        check(seen, "R6 lock", seen, 1);
        ratio_sel = 2'b00;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            check(clk_out == ((k == 5) || (k == 7) || (k == 9)), "R6 deferred change",
                  clk_out, int'((k == 5) || (k == 7) || (k == 9)));
        end

        // R8: routing of each auxiliary input
        ratio_sel = 2'b01;
        out_sel   = 2'b01;
        aux_clk   = 3'b001; @(negedge clk);
        check(clk_out == 1'b1, "R8 aux0 high", clk_out, 1);
        aux_clk   = 3'b110; @(negedge clk);
        check(clk_out == 1'b0, "R8 aux0 low", clk_out, 0);
        out_sel   = 2'b10;
        aux_clk   = 3'b010; @(negedge clk);
        check(clk_out == 1'b1, "R8 aux1 high", clk_out, 1);
        aux_clk   = 3'b101; @(negedge clk);
        check(clk_out == 1'b0, "R8 aux1 low", clk_out, 0);
        out_sel   = 2'b11;
        aux_clk   = 3'b100; @(negedge clk);
        check(clk_out == 1'b1, "R8 aux2 high", clk_out, 1);
        aux_clk   = 3'b011; @(negedge clk);
        check(clk_out == 1'b0, "R8 aux2 low", clk_out, 0);

        // R9: pulses keep coming at /1.5 while aux0 (held low) drives the pin
        out_sel = 2'b01;
        aux_clk = 3'b000;
        repeat (12) @(negedge clk);
        begin
            int pulses = 0;
            int highs  = 0;
            for (int i = 0; i < 15; i++) begin
                @(negedge clk);
                pulses += int'(irq_pulse);
                highs  += int'(clk_out);
            end
            check(pulses == 5, "R9 pulse count", pulses, 5);
            check(highs == 0, "R8 prescaler not leaking", highs, 0);
        end

        // R1: reset in mid-run
        out_sel = 2'b00;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(clk_out == 1'b0, "R1 mid-run clk_out", clk_out, 0);
        check(irq_pulse == 1'b0, "R1 mid-run irq", irq_pulse, 0);
        rst = 1'b0;

        report();
    end

endmodule